// File: doc/BRIEF.md
# Secret Key Loader for an Authenticated Cipher

This block owns the key of an authenticated cipher core. Key material reaches it only through a dedicated 32-bit secret input port with a valid/ready handshake. Each load on that port is one instruction word that asks for a key load, then one segment header, then the key words. The header must name a key segment and give a byte count equal to the configured key size. The words are gathered in a fill register. Once the last word is accepted, the complete key moves into a pending (shadow) register.

The cipher does not see a newly loaded key right away. A one-cycle activation strobe comes from the public-input decoder when it meets a key-activate instruction. On that strobe the pending key is copied into the active register that drives the cipher. The next key can therefore be loaded while the current one is still in use. The block has no public data input at all, so no public segment can reach the key storage.

Top module: `keyld_top`

## Requirements
- R1: After reset, `sdi_ready` is high and `key_valid`, `load_err` and every bit of `key_out` are low.
- R2: A word on `sdi_data` is consumed only in a cycle where `sdi_valid` and `sdi_ready` are both high. Data presented with `sdi_valid` low changes no state.
- R3: An instruction word is accepted as a key load only when bits [31:28] equal 4'b0100. Any other opcode sets `load_err`, and the loader keeps waiting for an instruction word.
- R4: A header is accepted only when its type bits [31:28] equal 4'b1100 and its length bits [15:0] equal KEY_W/8. Bits [27:16] are ignored. A mismatch sets `load_err`, leaves the pending key unchanged and returns the loader to waiting for an instruction.
- R5: The first key word fills `key_out[KEY_W-1 -: 32]`, and each later word fills the next lower 32 bits.
- R6: `key_out` changes only in the cycle after `act_strobe` is high, and it then shows the last completely loaded key.
- R7: Loading a new key, fully or partly, does not change `key_out` until the next activation. An activation during a load copies the previous complete key.
- R8: `sdi_ready` is low in every cycle in which `act_strobe` is high.
- R9: In the cycle after the last key word is accepted, `sdi_ready` is low for exactly one cycle. It is high again in the cycle after that.
- R10: `key_valid` goes high in the cycle after the first `act_strobe` and stays high until reset. This holds even if no key was loaded, in which case `key_out` is zero.
- R11: `load_err` is sticky and clears only when a valid load-key instruction word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| sdi_data | input | 32 | Secret input word |
| sdi_valid | input | 1 | Secret input word present |
| sdi_ready | output | 1 | Loader can take a word |
| act_strobe | input | 1 | One-cycle key-activate pulse from the public-input decoder |
| key_out | output | KEY_W | Active key presented to the cipher |
| key_valid | output | 1 | An activation has happened since reset |
| load_err | output | 1 | Sticky malformed instruction or header flag |

## Verification
Two events can fall in the same cycle: a key word arriving on the secret port and an activation strobe. The bench causes this by raising `act_strobe` in a cycle where `sdi_valid` already holds the first word of a new key. It then checks three things. `sdi_ready` must be low in that cycle, so the word is not taken. The active key must become the previous complete key, not a partial mix. The held word must be consumed in the following cycle. A second check covers an activation that lands right after a malformed header and confirms that the older key survives.

// File: rtl/keyld_pkg.sv
package keyld_pkg;
  localparam logic [3:0] OP_LOAD_KEY = 4'b0100;
  localparam logic [3:0] SEG_KEY     = 4'b1100;

  typedef enum logic [1:0] {
    P_INSTR = 2'd0,
    P_HDR   = 2'd1,
    P_DATA  = 2'd2,
    P_DONE  = 2'd3
  } parse_state_e;

  function automatic logic is_load_instr(input logic [31:0] w);
    return w[31:28] == OP_LOAD_KEY;
  endfunction

  function automatic logic is_key_hdr(input logic [31:0] w, input int unsigned nbytes);
    return (w[31:28] == SEG_KEY) && (w[15:0] == nbytes[15:0]);
  endfunction
endpackage

// File: rtl/keyld_sdi_parser.sv
module keyld_sdi_parser
  import keyld_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 4,
  parameter int unsigned KEY_BYTES = 16,
  localparam int unsigned CW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   sdi_data,
  input  logic          sdi_valid,
  output logic          sdi_ready,
  input  logic          act_strobe,
  output logic          word_wr,
  output logic [CW-1:0] word_idx,
  output logic          commit,
  output logic          err_evt,
  output logic          err_q,
  output logic          hs
);
  parse_state_e st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          good_instr;

  assign sdi_ready = (st_q != P_DONE) && !act_strobe;
  assign hs        = sdi_valid && sdi_ready;
  assign word_idx  = cnt_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    word_wr    = 1'b0;
    commit     = 1'b0;
    err_evt    = 1'b0;
    good_instr = 1'b0;
    unique case (st_q)
      P_INSTR: if (hs) begin
        if (is_load_instr(sdi_data)) begin
          good_instr = 1'b1;
          st_d       = P_HDR;
        end else begin
          err_evt = 1'b1;
        end
      end
      P_HDR: if (hs) begin
        if (is_key_hdr(sdi_data, KEY_BYTES)) begin
          st_d  = P_DATA;
          cnt_d = '0;
        end else begin
          err_evt = 1'b1;
          st_d    = P_INSTR;
        end
      end
      P_DATA: if (hs) begin
        word_wr = 1'b1;
        if (cnt_q == CW'(KEY_WORDS - 1)) begin
          commit = 1'b1;
          cnt_d  = '0;
          st_d   = P_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      P_DONE: st_d = P_INSTR;
      default: st_d = P_INSTR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= P_INSTR;
      cnt_q <= '0;
      err_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      if (err_evt)         err_q <= 1'b1;
      else if (good_instr) err_q <= 1'b0;
    end
  end
endmodule

// File: rtl/keyld_fill_bank.sv
module keyld_fill_bank #(
  parameter int unsigned KEY_W = 128,
  localparam int unsigned KEY_WORDS = KEY_W / 32,
  localparam int unsigned CW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             word_wr,
  input  logic [CW-1:0]    word_idx,
  input  logic [31:0]      word_data,
  output logic [KEY_W-1:0] fill_nxt
);
  logic [KEY_W-1:0] fill_q;

  function automatic logic [KEY_W-1:0] place_word(input logic [KEY_W-1:0] base,
                                                  input logic [CW-1:0] idx,
                                                  input logic [31:0] w);
    logic [KEY_W-1:0] r;
    r = base;
    r[KEY_W - 1 - 32 * int'(idx) -: 32] = w;
    return r;
  endfunction

  assign fill_nxt = word_wr ? place_word(fill_q, word_idx, word_data) : fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_nxt;
  end
endmodule

// File: rtl/keyld_key_store.sv
module keyld_key_store #(
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [KEY_W-1:0] fill_nxt,
  input  logic             act_strobe,
  output logic [KEY_W-1:0] shadow_q,
  output logic [KEY_W-1:0] active_q,
  output logic             valid_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow_q <= '0;
      active_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      if (commit) shadow_q <= fill_nxt;
      if (act_strobe) begin
        active_q <= shadow_q;
        valid_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/keyld_top.sv
module keyld_top #(
  parameter int unsigned KEY_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [31:0]      sdi_data,
  input  logic             sdi_valid,
  output logic             sdi_ready,
  input  logic             act_strobe,
  output logic [KEY_W-1:0] key_out,
  output logic             key_valid,
  output logic             load_err
);
  localparam int unsigned KEY_WORDS = KEY_W / 32;
  localparam int unsigned KEY_BYTES = KEY_W / 8;
  localparam int unsigned CW = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;

  logic             hs_evt;
  logic             commit_evt;
  logic             err_evt;
  logic             word_wr;
  logic [CW-1:0]    word_idx;
  logic [KEY_W-1:0] fill_nxt;
  logic [KEY_W-1:0] shadow_key;

  keyld_sdi_parser #(.KEY_WORDS(KEY_WORDS), .KEY_BYTES(KEY_BYTES)) u_parser (
    .clk, .rst_n, .sdi_data, .sdi_valid, .sdi_ready, .act_strobe,
    .word_wr, .word_idx, .commit(commit_evt), .err_evt, .err_q(load_err), .hs(hs_evt)
  );

  keyld_fill_bank #(.KEY_W(KEY_W)) u_fill (
    .clk, .rst_n, .word_wr, .word_idx, .word_data(sdi_data), .fill_nxt
  );

  keyld_key_store #(.KEY_W(KEY_W)) u_store (
    .clk, .rst_n, .commit(commit_evt), .fill_nxt, .act_strobe,
    .shadow_q(shadow_key), .active_q(key_out), .valid_q(key_valid)
  );
endmodule

// File: rtl/keyld_checker.sv
module keyld_checker #(
  parameter int unsigned KEY_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sdi_valid,
  input logic             sdi_ready,
  input logic             act_strobe,
  input logic [KEY_W-1:0] key_out,
  input logic             key_valid,
  input logic             load_err,
  input logic             hs_evt,
  input logic             commit_evt,
  input logic             err_evt,
  input logic [KEY_W-1:0] shadow_key
);
  AST_HS_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt |-> (sdi_valid && sdi_ready)); // R2
  AST_ERR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> $stable(shadow_key)); // R4
  AST_SHADOW_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_evt |=> $stable(shadow_key)); // R7
  AST_KEY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !act_strobe |=> $stable(key_out)); // R6
  AST_BUSY_ON_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    act_strobe |-> !sdi_ready); // R8
  AST_GAP_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |=> !sdi_ready); // R9
  AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> key_valid); // R10
  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_valid && !act_strobe) |=> !key_valid); // R10
  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |=> load_err); // R11
endmodule

bind keyld_top keyld_checker #(.KEY_W(KEY_W)) u_chk (
  .clk, .rst_n, .sdi_valid, .sdi_ready, .act_strobe, .key_out, .key_valid,
  .load_err, .hs_evt, .commit_evt, .err_evt, .shadow_key
);

// File: tb/keyld_top_test.sv
module keyld_top_test;
  localparam int KW = 128;
  localparam int NV = 6;
  // {instruction, header, kind}: kind 0 = good, 1 = bad opcode, 2 = bad header
  localparam logic [71:0] VEC [NV] = '{
    {32'h4000_0000, 32'hC000_0010, 8'd0},
    {32'h2000_0000, 32'h0000_0000, 8'd1},
    {32'h4000_0000, 32'h1000_0010, 8'd2},
    {32'h4000_0000, 32'hC000_000F, 8'd2},
    {32'h4ABC_0000, 32'hCF5A_0010, 8'd0},
    {32'h4000_0000, 32'hC000_0000, 8'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   sdi_data = '0;
  logic          sdi_valid = 1'b0;
  logic          sdi_ready;
  logic          act_strobe = 1'b0;
  logic [KW-1:0] key_out;
  logic          key_valid;
  logic          load_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [KW-1:0] last_key = '0;

  always #10 clk = ~clk;

  keyld_top #(.KEY_W(KW)) uut (
    .clk, .rst_n, .sdi_data, .sdi_valid, .sdi_ready, .act_strobe,
    .key_out, .key_valid, .load_err
  );

  function automatic logic [31:0] kword(input int v, input int k);
    return {8'(v + 8'h30), 8'(k + 8'h50), 16'hB7E1 ^ 16'(v * 16'h0101)};
  endfunction

  function automatic logic [KW-1:0] kfull(input int v);
    logic [KW-1:0] r;
    for (int k = 0; k < KW / 32; k++) r = {r[KW-33:0], kword(v, k)};
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [KW-1:0] act, input logic [KW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_word(input logic [31:0] w);
    @(negedge clk);
    sdi_valid = 1'b1;
    sdi_data  = w;
    while (!sdi_ready) @(negedge clk);
    @(negedge clk);
    sdi_valid = 1'b0;
  endtask

  task automatic activate(input logic [KW-1:0] exp, input string req);
    @(negedge clk);
    act_strobe = 1'b1;
    #1;
    chk(sdi_ready == 1'b0, "R8 ready low during activation", KW'(sdi_ready), '0);
    @(negedge clk);
    act_strobe = 1'b0;
    chk(key_out == exp, req, key_out, exp);
    chk(key_valid == 1'b1, "R10 key_valid after activation", KW'(key_valid), KW'(1));
  endtask

  task automatic load_words(input int v);
    for (int k = 0; k < KW / 32; k++) send_word(kword(v, k));
    chk(sdi_ready == 1'b0, "R9 ready low after last word", KW'(sdi_ready), '0);
    @(negedge clk);
    chk(sdi_ready == 1'b1, "R9 ready back after one cycle", KW'(sdi_ready), KW'(1));
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    chk(sdi_ready && !key_valid && !load_err && key_out == '0, "R1 reset state",
        {key_out[KW-1:3], sdi_ready, key_valid, load_err}, KW'(4));

    // R2 bad-opcode words with valid low are ignored
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      sdi_data = 32'h1000_0000 * i;
    end
    @(negedge clk);
    chk(load_err == 1'b0, "R2 data without valid ignored", KW'(load_err), '0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] ins, hdr;
      logic [7:0]  kind;
      {ins, hdr, kind} = VEC[v];
      send_word(ins);
      if (kind == 8'd1) begin
        chk(load_err == 1'b1, "R3 bad opcode flags error", KW'(load_err), KW'(1));
        chk(sdi_ready == 1'b1, "R3 still waiting for instruction", KW'(sdi_ready), KW'(1));
        activate(last_key, "R3 key unchanged after bad opcode");
      end else begin
        chk(load_err == 1'b0, "R11 error cleared by load instruction", KW'(load_err), '0);
        send_word(hdr);
        if (kind == 8'd2) begin
          chk(load_err == 1'b1, "R4 bad header flags error", KW'(load_err), KW'(1));
          activate(last_key, "R4 pending key unchanged after bad header");
        end else begin
          chk(load_err == 1'b0, "R4 good header accepted", KW'(load_err), '0);
          load_words(v);
          chk(key_out == last_key, "R7 key_out held until activation", key_out, last_key);
          last_key = kfull(v);
          activate(last_key, "R5 R6 key order after activation");
        end
      end
    end

    // collision: activation while first word of a new key is offered
    send_word(32'h4000_0000);
    send_word(32'hC000_0010);
    @(negedge clk);
    sdi_valid  = 1'b1;
    sdi_data   = kword(9, 0);
    act_strobe = 1'b1;
    #1;
    chk(sdi_ready == 1'b0, "R8 word held off during activation", KW'(sdi_ready), '0);
    @(negedge clk);
    act_strobe = 1'b0;
    chk(key_out == last_key, "R7 activation mid-load keeps complete key", key_out, last_key);
    @(negedge clk);
    sdi_valid = 1'b0;
    for (int k = 1; k < KW / 32; k++) send_word(kword(9, k));
    chk(sdi_ready == 1'b0, "R9 ready low after last word", KW'(sdi_ready), '0);
    last_key = kfull(9);
    activate(last_key, "R5 held word consumed after activation");

    // R10 activation with nothing loaded, then reset clears key_valid
    do_reset();
    chk(key_valid == 1'b0, "R10 key_valid cleared by reset", KW'(key_valid), '0);
    activate('0, "R10 activation before any load gives zero key");
    repeat (3) @(negedge clk);
    chk(key_valid == 1'b1, "R10 key_valid stays high", KW'(key_valid), KW'(1));

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule